// File: doc/BRIEF.md
# Keyed Countdown Watchdog Peripheral

The block is a watchdog timer reached through a single-cycle register interface (address, write strobe, write data, combinational read data). Software programs a reload value and a control word. The down-counter is refilled from the reload value only when a fixed key word is written to the restart register. If software stops writing the key, the counter runs out. The block then emits a one-cycle pulse on the outputs that the control word arms: a system reset request carrying a scope code, an interrupt, or an external expiry line.

The counter steps either on every bus clock or on a slow tick. A prescaler makes the slow tick from the bus clock, with the ratio set by the clock-frequency parameters (1 MHz by default). Writing the key clears the prescaler. After an expiry the counter refills itself and keeps running while enabled. All registers reset to zero, so the watchdog is disabled after reset. The bus has no handshake: every write takes effect at the clock edge where the write strobe is high, and reads return data in the same cycle.

Top module: `wdt_periph`

## Requirements
- R1: After reset every register reads zero, every pulse output is low and the counter does not move.
- R2: Offset 0x4 holds the reload value and 0xC the control word; both read back what was written. Control is 7 bits wide and its upper data bits read as zero. Offset 0x0 returns the live counter value. Offset 0x8 reads zero.
- R3: A write of exactly 32'h0000_4755 to offset 0x8 loads the counter from the reload register at that clock edge.
- R4: A write of any other value to offset 0x8 leaves the counter unchanged.
- R5: Control bit 0 enables counting, and each tick lowers the count by one. With bit 0 clear, the counter holds its value.
- R6: A tick that finds the enabled counter at zero refills it from the reload register. In the following cycle it produces a one-cycle pulse on the reset output if control bit 1 is set, on the interrupt output if bit 2 is set, and on the external output if bit 3 is set. Outputs whose bit is clear stay low.
- R7: The reset-scope output always shows control bits 6:5: 0 means core-only reset and 1 means full-chip reset.
- R8: With control bit 4 clear the counter ticks on every clock. With bit 4 set it ticks once every CLK_HZ/TICK_HZ clocks, and the first tick comes that many clocks after the last key write.
- R9: The sequence "clear control, write reload, write key, write control with enable" makes the counter start from the new reload value, whatever it was doing before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus and counter clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_addr | input | ADDR_W | register byte offset |
| bus_wr | input | 1 | write strobe, single cycle |
| bus_wdata | input | DATA_W | write data |
| bus_rdata | output | DATA_W | read data for bus_addr, same cycle |
| sys_rst_pulse | output | 1 | one-cycle reset request on expiry |
| rst_scope | output | 2 | reset scope code from control bits 6:5 |
| irq_pulse | output | 1 | one-cycle interrupt on expiry |
| ext_pulse | output | 1 | one-cycle external expiry signal |

## Verification
The countdown is run from several reload values: zero, which expires on every tick; small values, where each intermediate count is checked cycle by cycle; and a large value used to check the freeze. Each expiry pattern arms a different output alone, so that the single-cycle pulse shows which control bit is routed to which pin. Correct and wrong key words are written back to back, so that a refill can be told apart from a stale count. A slow-tick run checks that the prescaler restarts on the key write: it samples the cycle just before the first tick and the cycle of that tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CTRL_W = 7;
  localparam logic [3:0] OFF_STATUS  = 4'h0;
  localparam logic [3:0] OFF_RELOAD  = 4'h4;
  localparam logic [3:0] OFF_RESTART = 4'h8;
  localparam logic [3:0] OFF_CTRL    = 4'hC;
  localparam logic [31:0] KICK_KEY   = 32'h0000_4755;

  // packed order fixes the bit positions: scope[6:5] .. en[0]
  typedef struct packed {
    logic [1:0] scope;
    logic       slow;
    logic       ext;
    logic       irq;
    logic       rst;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/wdt_ticker.sv
module wdt_ticker #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic slow_sel,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;
  logic          wrap;

  assign wrap = (pcnt == LAST);
  assign tick = slow_sel ? wrap : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pcnt <= '0;
    else if (clear || wrap) pcnt <= '0;
    else                    pcnt <= pcnt + 1'b1;
  end

  assert_prescale_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pcnt == '0));
  assert_prescale_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= LAST);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  input  logic             enable,
  input  logic             tick,
  input  logic             arm_rst,
  input  logic             arm_irq,
  input  logic             arm_ext,
  output logic [CNT_W-1:0] count,
  output logic             rst_o,
  output logic             irq_o,
  output logic             ext_o
);
  logic step, expire;

  assign step   = enable && tick && !restart;
  assign expire = step && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      rst_o <= 1'b0;
      irq_o <= 1'b0;
      ext_o <= 1'b0;
    end else begin
      rst_o <= expire && arm_rst;
      irq_o <= expire && arm_irq;
      ext_o <= expire && arm_ext;
      if (restart || expire) count <= reload;
      else if (step)         count <= count - 1'b1;
    end
  end

  assert_key_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == $past(reload)));
  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !restart) |=> $stable(count));
  assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count != '0) |=> (count == $past(count) - 1'b1));
  assert_expiry_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count == '0) |=> (count == $past(reload)));
  assert_irq_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(arm_irq));
endmodule

// File: rtl/wdt_periph.sv
module wdt_periph #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 1_000_000,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst_pulse,
  output logic [1:0]        rst_scope,
  output logic              irq_pulse,
  output logic              ext_pulse
);
  import wdt_pkg::*;
  localparam int DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             restart, tick;
  logic [3:0]       off;

  assign off = 4'(bus_addr);
  assign restart = bus_wr && (off == OFF_RESTART) && (32'(bus_wdata) == KICK_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
    end else if (bus_wr) begin
      if (off == OFF_RELOAD) reload <= bus_wdata[CNT_W-1:0];
      if (off == OFF_CTRL)   ctrl   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end
  end

  always_comb begin
    case (off)
      OFF_STATUS: bus_rdata = DATA_W'(count);
      OFF_RELOAD: bus_rdata = DATA_W'(reload);
      OFF_CTRL:   bus_rdata = DATA_W'(ctrl);
      default:    bus_rdata = '0;
    endcase
  end

  assign rst_scope = ctrl.scope;

  wdt_ticker #(.DIV(DIV)) u_ticker (
    .clk(clk), .rst_n(rst_n), .clear(restart), .slow_sel(ctrl.slow), .tick(tick)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .restart(restart), .reload(reload),
    .enable(ctrl.en), .tick(tick), .arm_rst(ctrl.rst), .arm_irq(ctrl.irq),
    .arm_ext(ctrl.ext), .count(count), .rst_o(sys_rst_pulse),
    .irq_o(irq_pulse), .ext_o(ext_pulse)
  );

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && off == OFF_CTRL) |=> (bus_rdata[CTRL_W-1:0] == $past(bus_wdata[CTRL_W-1:0])
                                     || off != OFF_CTRL));
  assert_bad_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && off == OFF_RESTART && 32'(bus_wdata) != KICK_KEY && !ctrl.en) |=> $stable(count));
  assert_pulse_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> $past(ctrl.rst));
endmodule

// File: tb/test_wdt_periph.sv
module test_wdt_periph;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst_pulse, irq_pulse, ext_pulse;
  logic [1:0]  rst_scope;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdt_periph i_wdt_periph (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_pulse(sys_rst_pulse),
    .rst_scope(rst_scope), .irq_pulse(irq_pulse), .ext_pulse(ext_pulse)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  function automatic logic [31:0] pulses();
    return {29'd0, ext_pulse, irq_pulse, sys_rst_pulse};
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), d); chk("R1 register zero", d, 0);
    end
    chk("R1 pulses low", pulses(), 0);
    step(3); rd(4'h0, d); chk("R1 counter idle", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(4'h4, 32'hDEAD_BEEF); rd(4'h4, d); chk("R2 reload readback", d, 32'hDEAD_BEEF);
    wr(4'hC, 32'hFFFF_FF80); rd(4'hC, d); chk("R2 ctrl upper zero", d, 0);
    wr(4'hC, 32'h0000_0056); rd(4'hC, d); chk("R2 ctrl readback", d, 32'h56);
    chk("R7 scope mirrors ctrl", 32'(rst_scope), 2);
    wr(4'hC, 0);
    rd(4'h8, d); chk("R2 restart reads zero", d, 0);
  endtask

  task automatic t_key;
    logic [31:0] d;
    wr(4'h4, 100); wr(4'h8, 32'h4755); rd(4'h0, d); chk("R3 key loads", d, 100);
    wr(4'h4, 7); wr(4'h8, 32'h4754); rd(4'h0, d); chk("R4 wrong key ignored", d, 100);
    wr(4'h8, 32'h0001_4755); rd(4'h0, d); chk("R4 upper bits ignored", d, 100);
    wr(4'h8, 32'h4755); rd(4'h0, d); chk("R3 key reloads new value", d, 7);
  endtask

  task automatic t_fast_expiry;
    logic [31:0] d;
    wr(4'hC, 0); wr(4'h4, 5); wr(4'h8, 32'h4755);
    wr(4'hC, 32'h23);
    rd(4'h0, d); chk("R5 no tick while being enabled", d, 5);
    for (int k = 1; k <= 5; k++) begin
      step(1); rd(4'h0, d); chk("R5 decrement", d, 32'(5 - k));
      chk("R6 no early pulse", pulses(), 0);
    end
    step(1); rd(4'h0, d);
    chk("R6 reset pulse only", pulses(), 1);
    chk("R7 full chip scope", 32'(rst_scope), 1);
    chk("R6 refill on expiry", d, 5);
    step(1); rd(4'h0, d);
    chk("R6 pulse one cycle", pulses(), 0);
    chk("R6 continues after refill", d, 4);
    wr(4'hC, 0);
  endtask

  task automatic t_irq_ext;
    wr(4'h4, 0); wr(4'h8, 32'h4755); wr(4'hC, 32'h05);
    step(1); chk("R6 irq pulse only", pulses(), 2);
    wr(4'hC, 0); step(1);
    wr(4'h4, 3); wr(4'h8, 32'h4755); wr(4'hC, 32'h09);
    step(3); chk("R6 ext not yet", pulses(), 0);
    step(1); chk("R6 ext pulse only", pulses(), 4);
    wr(4'hC, 0);
    wr(4'h4, 1); wr(4'h8, 32'h4755); wr(4'hC, 32'h03);
    step(2); chk("R6 reset pulse", pulses(), 1);
    chk("R7 core scope", 32'(rst_scope), 0);
    wr(4'hC, 0);
  endtask

  task automatic t_freeze;
    logic [31:0] d;
    wr(4'h4, 20); wr(4'h8, 32'h4755); wr(4'hC, 32'h03);
    step(3); rd(4'h0, d); chk("R5 running", d, 17);
    wr(4'hC, 32'h02); rd(4'h0, d); chk("R5 last step", d, 16);
    step(5); rd(4'h0, d); chk("R5 frozen", d, 16);
    chk("R5 no pulse when frozen", pulses(), 0);
    wr(4'hC, 0);
  endtask

  task automatic t_slow;
    logic [31:0] d;
    wr(4'h4, 2); wr(4'h8, 32'h4755); wr(4'hC, 32'h11);
    step(48); rd(4'h0, d); chk("R8 no tick before divider", d, 2);
    step(1); rd(4'h0, d); chk("R8 first slow tick", d, 1);
    step(49); rd(4'h0, d); chk("R8 between slow ticks", d, 1);
    step(1); rd(4'h0, d); chk("R8 second slow tick", d, 0);
    wr(4'hC, 0);
  endtask

  task automatic t_sequence;
    logic [31:0] d;
    wr(4'h4, 50); wr(4'h8, 32'h4755); wr(4'hC, 32'h03); step(4);
    wr(4'hC, 0); wr(4'h4, 3); wr(4'h8, 32'h4755); wr(4'hC, 32'h03);
    rd(4'h0, d); chk("R9 starts from new reload", d, 3);
    step(3); rd(4'h0, d); chk("R9 counts new value", d, 0);
    step(1); chk("R9 expiry on schedule", pulses(), 1);
    wr(4'hC, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_regs(); t_key(); t_fast_expiry();
    t_irq_ext(); t_freeze(); t_slow(); t_sequence();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule